// File: doc/BRIEF.md
# Reset Cause and Processor Control Register

This block keeps a small control and status register next to a processor core. It remembers why the core was last reset, watchdog expiry or power-on, and holds two software controls: one that puts the core to sleep until an interrupt arrives and one that halts it until the next reset. It also produces the core's reset pulse, the strobe that restarts fetching at address 0x0000, a reload pulse for the sleep/watchdog interval timer, and the clock-divider selection that applies after power-up.

Three reset sources feed it. The power-on input is asynchronous and is first passed through a two-stage synchroniser. The external reset is a synchronous level. The watchdog expiry is a one-cycle pulse, and it counts only after software has acknowledged the last power-on by clearing the power-on flag. Any accepted reset event starts a stretch counter that holds the core in reset for at least `RST_HOLD` cycles. When the core leaves reset, both strobes pulse for one cycle. Software reaches two locations through a one-bit select: the control/status byte and the clock-divider byte.

Top module: `rstcause_ctl`

## Requirements
- R1: With select 0 the read value is: bit 7 = interrupt-enable mirror (forced to 0 while the core reset is active), bit 5 = watchdog flag, bit 4 = power-on flag, bit 3 = sleep, bit 0 = stop. Bits 6, 2 and 1 read 0. With select 1 the read value is {5'b0, divider code}.
- R2: A write with select 0 clears the watchdog flag when data bit 5 is 0 and clears the power-on flag when data bit 4 is 0. Writing 1 to either bit leaves that flag unchanged, so software can never set a flag.
- R3: After a power-on reset the power-on flag is 1, the watchdog flag is 0, sleep and stop are 0, and the divider code is 3'b011 (divide-by-8). No other reset changes the divider code.
- R4: A watchdog pulse while the power-on flag is 0 sets the watchdog flag and resets the core. While the power-on flag is 1, the pulse causes no reset and the watchdog flag does not change.
- R5: Writing 1 to bit 3 raises the sleep request, which stays high until the interrupt-pending input is 1. That clears the bit. If a pending interrupt coincides with the write, the bit stays 0.
- R6: Writing 1 to bit 0 raises the halt request. It stays high while interrupts are pending and drops only on a reset or a software write of 0.
- R7: Every accepted reset event (power-on, external, watchdog) holds the core reset high for exactly `RST_HOLD` cycles after the event ends (default 4), and clears sleep and stop.
- R8: In the first cycle after the core reset falls, the vector-load and timer-reload outputs are both 1 for exactly one cycle.
- R9: An external reset leaves both cause flags and the divider code unchanged.
- R10: Register writes are ignored while the core reset is high.
- R11: If a watchdog pulse arrives in the same cycle as a software write that clears the watchdog flag, the flag ends up set.
- R12: The power-on input reaches the core reset after a two-flop synchroniser. The core reset rises on the third rising edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_async_i | input | 1 | Power-on reset, asynchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous level, active high |
| wdt_expire_i | input | 1 | One-cycle watchdog expiry pulse |
| irq_pending_i | input | 1 | Some interrupt is pending |
| gie_i | input | 1 | Global interrupt enable from the core flags |
| reg_sel_i | input | 1 | 0 = control/status byte, 1 = divider byte |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected byte |
| sleep_req_o | output | 1 | Sleep request to the core |
| halt_req_o | output | 1 | Halt request to the core |
| core_rst_o | output | 1 | Synchronous core reset |
| vec_load_o | output | 1 | One-cycle strobe to restart at address 0x0000 |
| wdt_reload_o | output | 1 | One-cycle strobe to reload the interval timer to its minimum |
| clkdiv_sel_o | output | 3 | Clock-divider code (3'b011 = divide-by-8) |

## Verification
Two pairs of functions can fall in the same cycle here.

- **Watchdog flag.** A hardware set can meet a software clear. The bench drives a watchdog pulse in the same cycle as a write of 0x00. It then requires a full reset and a flag that reads back as 1.
- **Sleep bit.** A software set can meet an interrupt-pending release. One table row writes sleep and stop together while an interrupt is pending. It expects the sleep request low, the halt request high and the power-on flag cleared by the same write.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned DIV_W     = 3;

    localparam int unsigned POS_GIE   = 7;
    localparam int unsigned POS_WDOG  = 5;
    localparam int unsigned POS_PWRON = 4;
    localparam int unsigned POS_SLEEP = 3;
    localparam int unsigned POS_STOP  = 0;

    localparam logic [DIV_W-1:0] DIV_BY8 = 3'b011;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DIV  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic wdog;
        logic pwron;
        logic sleep;
        logic stop;
    } cause_flags_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input cause_flags_t f, input logic gie);
        logic [DATA_W-1:0] v;
        v            = '0;
        v[POS_GIE]   = gie;
        v[POS_WDOG]  = f.wdog;
        v[POS_PWRON] = f.pwron;
        v[POS_SLEEP] = f.sleep;
        v[POS_STOP]  = f.stop;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_div(input logic [DIV_W-1:0] d);
        return {{(DATA_W-DIV_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/rstcause_sync.sv
module rstcause_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rstcause_seq.sv
module rstcause_seq #(
    parameter int unsigned RST_HOLD = 4
) (
    input  logic clk,
    input  logic por_sync_i,
    input  logic ext_rst_i,
    input  logic wdt_hit_i,
    output logic rst_event_o,
    output logic core_rst_o,
    output logic release_o
);
    localparam int unsigned CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(RST_HOLD);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] hold_cnt;
    logic             rel_q;

    assign rst_event_o = por_sync_i | ext_rst_i | wdt_hit_i;

    always_ff @(posedge clk) begin
        if (por_sync_i) begin
            hold_cnt <= HOLD_V;
            rel_q    <= 1'b0;
        end else begin
            rel_q <= (hold_cnt == ONE_V) && !rst_event_o;
            if (rst_event_o) begin
                hold_cnt <= HOLD_V;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - ONE_V;
            end
        end
    end

    assign core_rst_o = (hold_cnt != '0);
    assign release_o  = rel_q;
endmodule

// File: rtl/rstcause_regs.sv
module rstcause_regs
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst_i,
    input  logic              ctl_rst_i,
    input  logic              wr_en_i,
    input  reg_sel_e          wr_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wdt_hit_i,
    input  logic              irq_pending_i,
    output cause_flags_t      flags_o,
    output logic [DIV_W-1:0]  div_o
);
    cause_flags_t     flags_q;
    logic [DIV_W-1:0] div_q;
    logic             wr_ctrl;
    logic             wr_div;
    logic             unused_wdata;

    assign wr_ctrl      = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign wr_div       = wr_en_i && (wr_sel_i == SEL_DIV);
    assign unused_wdata = ^wdata_i[DATA_W-1:POS_WDOG+1];

    // cause flags: hardware sets, software only clears
    always_ff @(posedge clk) begin
        if (por_rst_i) begin
            flags_q.wdog  <= 1'b0;
            flags_q.pwron <= 1'b1;
        end else begin
            if (wdt_hit_i) begin
                flags_q.wdog <= 1'b1;
            end else if (wr_ctrl && !wdata_i[POS_WDOG]) begin
                flags_q.wdog <= 1'b0;
            end
            if (wr_ctrl && !wdata_i[POS_PWRON]) begin
                flags_q.pwron <= 1'b0;
            end
        end
    end

    // software controls, cleared by any reset
    always_ff @(posedge clk) begin
        if (ctl_rst_i) begin
            flags_q.sleep <= 1'b0;
            flags_q.stop  <= 1'b0;
        end else begin
            if (irq_pending_i) begin
                flags_q.sleep <= 1'b0;
            end else if (wr_ctrl) begin
                flags_q.sleep <= wdata_i[POS_SLEEP];
            end
            if (wr_ctrl) begin
                flags_q.stop <= wdata_i[POS_STOP];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst_i) begin
            div_q <= DIV_BY8;
        end else if (wr_div) begin
            div_q <= wdata_i[DIV_W-1:0];
        end
    end

    assign flags_o = flags_q;
    assign div_o   = div_q;
endmodule

// File: rtl/rstcause_ctl.sv
module rstcause_ctl
    import rstcause_pkg::*;
#(
    parameter int unsigned RST_HOLD    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_async_i,
    input  logic              ext_rst_i,
    input  logic              wdt_expire_i,
    input  logic              irq_pending_i,
    input  logic              gie_i,
    input  logic              reg_sel_i,
    input  logic              reg_we_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              sleep_req_o,
    output logic              halt_req_o,
    output logic              core_rst_o,
    output logic              vec_load_o,
    output logic              wdt_reload_o,
    output logic [2:0]        clkdiv_sel_o
);
    logic             por_sync;
    logic             wdt_hit;
    logic             rst_event;
    logic             core_rst;
    logic             release_pulse;
    cause_flags_t     flags;
    logic [DIV_W-1:0] div_code;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_sel_i);

    rstcause_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk     (clk),
        .async_i (por_async_i),
        .sync_o  (por_sync)
    );

    // watchdog counts only once the power-on flag has been acknowledged
    assign wdt_hit = wdt_expire_i && !flags.pwron && !por_sync;

    rstcause_seq #(.RST_HOLD(RST_HOLD)) u_seq (
        .clk         (clk),
        .por_sync_i  (por_sync),
        .ext_rst_i   (ext_rst_i),
        .wdt_hit_i   (wdt_hit),
        .rst_event_o (rst_event),
        .core_rst_o  (core_rst),
        .release_o   (release_pulse)
    );

    rstcause_regs u_regs (
        .clk           (clk),
        .por_rst_i     (por_sync),
        .ctl_rst_i     (rst_event | core_rst),
        .wr_en_i       (reg_we_i && !core_rst),
        .wr_sel_i      (sel),
        .wdata_i       (reg_wdata_i),
        .wdt_hit_i     (wdt_hit),
        .irq_pending_i (irq_pending_i),
        .flags_o       (flags),
        .div_o         (div_code)
    );

    always_comb begin
        if (sel == SEL_DIV) begin
            reg_rdata_o = pack_div(div_code);
        end else begin
            reg_rdata_o = pack_ctrl(flags, gie_i && !core_rst);
        end
    end

    assign sleep_req_o  = flags.sleep;
    assign halt_req_o   = flags.stop;
    assign core_rst_o   = core_rst;
    assign vec_load_o   = release_pulse;
    assign wdt_reload_o = release_pulse;
    assign clkdiv_sel_o = div_code;
endmodule

// File: rtl/rstcause_ctl_chk.sv
module rstcause_ctl_chk (
    input logic       clk,
    input logic       por_sync,
    input logic       core_rst_o,
    input logic       wdt_expire_i,
    input logic       ext_rst_i,
    input logic       irq_pending_i,
    input logic       pors_q,
    input logic       wdrs_q,
    input logic       sleep_req_o,
    input logic       halt_req_o,
    input logic       vec_load_o,
    input logic       wdt_reload_o,
    input logic [7:0] reg_rdata_o,
    input logic       reg_sel_i,
    input logic       reg_we_i,
    input logic [7:0] reg_wdata_i
);
    logic armed;

    always_ff @(posedge clk) begin
        armed <= armed | por_sync;
    end

    assert_no_sw_set_wdog_R2: assert property (@(posedge clk) disable iff (!armed)
        $rose(wdrs_q) |-> $past(wdt_expire_i));

    assert_no_sw_set_pwron_R2: assert property (@(posedge clk) disable iff (!armed)
        $rose(pors_q) |-> $past(por_sync));

    assert_wdog_blocked_R4: assert property (@(posedge clk) disable iff (!armed)
        (wdt_expire_i && pors_q && !por_sync && !ext_rst_i && !core_rst_o)
        |=> (!core_rst_o && wdrs_q == $past(wdrs_q)));

    assert_wdog_wins_R11: assert property (@(posedge clk) disable iff (!armed)
        (wdt_expire_i && !pors_q && !por_sync) |=> (wdrs_q && core_rst_o));

    assert_sleep_exit_R5: assert property (@(posedge clk) disable iff (!armed)
        (sleep_req_o && irq_pending_i) |=> !sleep_req_o);

    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!armed)
        (halt_req_o && !core_rst_o && !(reg_we_i && !reg_sel_i && !reg_wdata_i[0]))
        |=> (halt_req_o || core_rst_o));

    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!armed)
        (core_rst_o && !reg_sel_i) |-> (!reg_rdata_o[7] && !sleep_req_o && !halt_req_o));

    assert_release_strobe_R8: assert property (@(posedge clk) disable iff (!armed)
        $fell(core_rst_o) |-> (vec_load_o && wdt_reload_o));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!armed)
        vec_load_o |=> !vec_load_o);
endmodule

bind rstcause_ctl rstcause_ctl_chk u_chk (
    .clk           (clk),
    .por_sync      (por_sync),
    .core_rst_o    (core_rst_o),
    .wdt_expire_i  (wdt_expire_i),
    .ext_rst_i     (ext_rst_i),
    .irq_pending_i (irq_pending_i),
    .pors_q        (flags.pwron),
    .wdrs_q        (flags.wdog),
    .sleep_req_o   (sleep_req_o),
    .halt_req_o    (halt_req_o),
    .vec_load_o    (vec_load_o),
    .wdt_reload_o  (wdt_reload_o),
    .reg_rdata_o   (reg_rdata_o),
    .reg_sel_i     (reg_sel_i),
    .reg_we_i      (reg_we_i),
    .reg_wdata_i   (reg_wdata_i)
);

// File: tb/rstcause_ctl_tb.sv
module rstcause_ctl_tb;
    logic       clk = 1'b0;
    logic       por_async_i = 1'b1;
    logic       ext_rst_i = 1'b0;
    logic       wdt_expire_i = 1'b0;
    logic       irq_pending_i = 1'b0;
    logic       gie_i = 1'b1;
    logic       reg_sel_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       sleep_req_o, halt_req_o, core_rst_o, vec_load_o, wdt_reload_o;
    logic [2:0] clkdiv_sel_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int n_hold;

    always #2 clk = ~clk;

    rstcause_ctl u_dut (
        .clk(clk), .por_async_i(por_async_i), .ext_rst_i(ext_rst_i),
        .wdt_expire_i(wdt_expire_i), .irq_pending_i(irq_pending_i), .gie_i(gie_i),
        .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .sleep_req_o(sleep_req_o), .halt_req_o(halt_req_o),
        .core_rst_o(core_rst_o), .vec_load_o(vec_load_o), .wdt_reload_o(wdt_reload_o),
        .clkdiv_sel_o(clkdiv_sel_o)
    );

    // {we, sel, wdata, irq, exp_sleep, exp_halt, exp_rdata}
    localparam logic [20:0] VEC [0:8] = '{
        {1'b1, 1'b0, 8'h18, 1'b0, 1'b1, 1'b0, 8'h98},
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h98},
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h90},
        {1'b1, 1'b0, 8'h09, 1'b1, 1'b0, 1'b1, 8'h81},
        {1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 8'h80},
        {1'b1, 1'b1, 8'hFD, 1'b0, 1'b0, 1'b0, 8'h05},
        {1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h89},
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h81},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h05}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (core_rst_o && n < 100) begin
            n++;
            step();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog all-reqs: actual cycles=%0d expected below 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) step();
        por_async_i = 1'b0;
        wait_release(n_hold);
        check("R8 vec_load after power-on", {7'b0, vec_load_o}, 8'h01);
        check("R8 wdt_reload after power-on", {7'b0, wdt_reload_o}, 8'h01);
        step();
        check("R8 vec_load single cycle", {7'b0, vec_load_o}, 8'h00);
        check("R3 R1 control byte after power-on", reg_rdata_o, 8'h90);
        check("R3 sleep/halt after power-on", {6'b0, sleep_req_o, halt_req_o}, 8'h00);
        reg_sel_i = 1'b1; #1;
        check("R3 divider byte is divide-by-8", reg_rdata_o, 8'h03);
        check("R3 divider output", {5'b0, clkdiv_sel_o}, 8'h03);
        reg_sel_i = 1'b0; gie_i = 1'b0; #1;
        check("R1 interrupt-enable mirror low", reg_rdata_o, 8'h10);
        gie_i = 1'b1;

        // R4: watchdog ignored while power-on flag set
        wdt_expire_i = 1'b1; step(); wdt_expire_i = 1'b0;
        check("R4 no reset while power-on flag set", {7'b0, core_rst_o}, 8'h00);
        step();
        check("R4 watchdog flag unchanged", reg_rdata_o, 8'h90);

        // table walk: R1 R2 R5 R6
        for (int i = 0; i < 9; i++) begin
            {reg_we_i, reg_sel_i, reg_wdata_i, irq_pending_i} = VEC[i][20:10];
            step();
            check($sformatf("R5 R6 row %0d sleep", i), {7'b0, sleep_req_o}, {7'b0, VEC[i][9]});
            check($sformatf("R6 row %0d halt", i), {7'b0, halt_req_o}, {7'b0, VEC[i][8]});
            check($sformatf("R1 R2 row %0d read", i), reg_rdata_o, VEC[i][7:0]);
        end
        reg_we_i = 1'b0; irq_pending_i = 1'b0; reg_sel_i = 1'b0;

        // watchdog reset with power-on flag clear: R4 R6 R7 R8
        wdt_expire_i = 1'b1; step(); wdt_expire_i = 1'b0;
        check("R4 watchdog reset starts", {7'b0, core_rst_o}, 8'h01);
        check("R7 read during reset", reg_rdata_o, 8'h20);
        wait_release(n_hold);
        check("R7 reset hold length", 8'(n_hold), 8'd4);
        check("R8 vec_load after watchdog reset", {7'b0, vec_load_o}, 8'h01);
        check("R8 wdt_reload after watchdog reset", {7'b0, wdt_reload_o}, 8'h01);
        check("R6 halt released by reset", {7'b0, halt_req_o}, 8'h00);
        check("R4 watchdog flag set", reg_rdata_o, 8'hA0);
        reg_sel_i = 1'b1; #1;
        check("R3 divider kept on watchdog reset", reg_rdata_o, 8'h05);
        reg_sel_i = 1'b0;

        // R2: clear watchdog flag
        reg_we_i = 1'b1; reg_wdata_i = 8'h00; step(); reg_we_i = 1'b0;
        check("R2 watchdog flag cleared", reg_rdata_o, 8'h80);

        // R11: watchdog meets software clear
        reg_we_i = 1'b1; reg_wdata_i = 8'h00; wdt_expire_i = 1'b1; step();
        reg_we_i = 1'b0; wdt_expire_i = 1'b0;
        check("R11 reset taken", {7'b0, core_rst_o}, 8'h01);
        wait_release(n_hold);
        check("R11 watchdog flag wins", reg_rdata_o, 8'hA0);

        // R9 R10: external reset, writes during reset
        reg_we_i = 1'b1; reg_wdata_i = 8'h28; step(); reg_we_i = 1'b0;
        check("R5 sleep set before external reset", {7'b0, sleep_req_o}, 8'h01);
        ext_rst_i = 1'b1; step(); ext_rst_i = 1'b0;
        check("R7 external reset starts", {7'b0, core_rst_o}, 8'h01);
        check("R7 sleep cleared by external reset", {7'b0, sleep_req_o}, 8'h00);
        reg_we_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 8'h08; step();
        reg_sel_i = 1'b1; reg_wdata_i = 8'h00; step();
        reg_we_i = 1'b0; reg_sel_i = 1'b0;
        wait_release(n_hold);
        check("R9 R10 flags kept, write ignored", reg_rdata_o, 8'hA0);
        check("R10 sleep not set during reset", {7'b0, sleep_req_o}, 8'h00);
        reg_sel_i = 1'b1; #1;
        check("R9 R10 divider unchanged", reg_rdata_o, 8'h05);
        reg_sel_i = 1'b0;

        // R12: synchroniser latency, then R3 again
        reg_we_i = 1'b1; reg_wdata_i = 8'h01; step(); reg_we_i = 1'b0;
        por_async_i = 1'b1;
        step();
        check("R12 no reset after 1 edge", {7'b0, core_rst_o}, 8'h00);
        step();
        check("R12 no reset after 2 edges", {7'b0, core_rst_o}, 8'h00);
        step();
        check("R12 reset on 3rd edge", {7'b0, core_rst_o}, 8'h01);
        repeat (3) step();
        por_async_i = 1'b0;
        wait_release(n_hold);
        check("R3 control byte after second power-on", reg_rdata_o, 8'h90);
        check("R3 halt cleared", {7'b0, halt_req_o}, 8'h00);
        reg_sel_i = 1'b1; #1;
        check("R3 divider restored", reg_rdata_o, 8'h03);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule